// File: doc/BRIEF.md
# Dual-Source Vectored Interrupt Requester

This block raises a prioritised, vectored bus interrupt on behalf of two event sources: a capture source (change-of-state or sequence-of-events data entering a capture FIFO) and a quadrature marker pulse source. A control byte gives each source an enable bit and a 3-bit level. Each source also has its own 8-bit vector register. A pending, enabled source with a non-zero level pulls one of seven active-low interrupt lines low.

When the host runs an interrupt-acknowledge cycle for a level, the block checks whether a pending source sits at that level. If one does, the block returns that source's vector together with a one-cycle done strobe. The marker source is always released by that acknowledge. The capture source is released either by the acknowledge or only once its FIFO reports empty, depending on a separate mode input. Clearing a source's enable bit withdraws its request at once.

Requests are latched on the rising edge of each source's event input. The asynchronous reset is released synchronously inside the block, so the block leaves reset two clock cycles after `rst_n` goes high.

Top module: `dual_irq_requester`

## Requirements
- R1: After reset, the control byte and both vector registers read 0x00, all seven interrupt lines are high, `iack_done` is 0 and `iack_vector` is 0x00.
- R2: A write with `wr_en` stores `wr_data` into the register picked by `wr_sel`. The encodings are 0 = control byte, 1 = capture vector and 2 = marker vector. Code 3 is not a register. `rd_data` shows the register picked by `rd_sel`, and code 3 reads 0x00.
- R3: In the control byte, bit 3 is the capture enable and bits 2:0 are the capture level. Bit 7 is the marker enable and bits 6:4 are the marker level. A pending, enabled source with level code L from 1 to 7 drives `irq_n[L]` low and leaves every other line high. Level code 0 drives no line.
- R4: A request is latched on the clock edge that first samples a 0-to-1 transition of the source's event input while the source is enabled. The matching line goes low from that edge onward. Holding the event input high does not latch the request again after it has been released.
- R5: When `iack_valid` is sampled with `iack_level` equal to the level of a pending, enabled source, the next cycle shows `iack_done` = 1 and `iack_vector` set to that source's vector, for one cycle. If no such source exists, `iack_done` stays 0 and `iack_vector` stays 0x00, and no request changes.
- R6: With `release_on_empty` = 0, an acknowledge served to the capture source releases its request on the same edge.
- R7: With `release_on_empty` = 1, an acknowledge served to the capture source still returns its vector but leaves the request asserted. The request is released on the edge that samples `fifo_empty` = 1.
- R8: Writing a control byte that clears a source's enable bit withdraws that source's request on the same edge as the write. The request stays withdrawn when the source is enabled again.
- R9: An acknowledge served to the marker source releases its request whatever the value of `release_on_empty`.
- R10: When both sources are pending at the acknowledged level, the marker vector is returned and the capture request stays asserted. A second acknowledge then returns the capture vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register picked for the write (0 control, 1 capture vector, 2 marker vector) |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Register picked for the read |
| rd_data | output | 8 | Read data (combinational) |
| release_on_empty | input | 1 | Capture release mode: 0 = on acknowledge, 1 = on FIFO empty |
| fifo_empty | input | 1 | Capture FIFO empty flag |
| cap_event | input | 1 | Capture source event, latched on its rising edge |
| mkr_event | input | 1 | Marker source event, latched on its rising edge |
| iack_valid | input | 1 | Interrupt-acknowledge cycle strobe |
| iack_level | input | 3 | Level being acknowledged |
| iack_done | output | 1 | One-cycle strobe marking a served acknowledge |
| iack_vector | output | 8 | Vector of the served source, 0x00 otherwise |
| irq_n | output | 7 | Active-low interrupt lines; irq_n[L] is level L (indices 7:1) |

## Verification
Each result falls due at a known clock edge. A register write is visible on `rd_data` after the edge that samples it. A request shows on `irq_n` after the edge that samples the event's rising transition. The done strobe, the vector and any release follow the edge that samples `iack_valid`. A withdrawal by enable-clear, or a release by `fifo_empty`, follows the edge that samples the write or the flag. The bench changes every input just after a falling edge and reads the outputs at the next falling edge, so each check falls exactly one rising edge after its stimulus. Checks that something must persist, such as a held event input or a capture request after an acknowledge, sample again after further edges.

// File: rtl/irq_req_pkg.sv
package irq_req_pkg;
  localparam int VEC_W   = 8;
  localparam int LVL_W   = 3;
  localparam int NUM_LVL = (1 << LVL_W) - 1;
  localparam int NUM_SRC = 2;
  localparam int SRC_CAP = 0;
  localparam int SRC_MKR = 1;
  localparam int NIB_W   = LVL_W + 1;

  typedef struct packed {
    logic             en;
    logic [LVL_W-1:0] lvl;
  } src_cfg_t;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CVEC = 2'd1,
    SEL_MVEC = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_reg_file.sv
module irq_reg_file
  import irq_req_pkg::*;
(
  input  logic             clk,
  input  logic             rst_q,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [VEC_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [VEC_W-1:0] rd_data,
  output logic [VEC_W-1:0] ctrl_q,
  output logic [VEC_W-1:0] cvec_q,
  output logic [VEC_W-1:0] mvec_q
);
  logic [VEC_W-1:0] ctrl_d, cvec_d, mvec_d;

  always_comb begin
    ctrl_d = ctrl_q;
    cvec_d = cvec_q;
    mvec_d = mvec_q;
    if (wr_en) begin
      unique case (reg_sel_e'(wr_sel))
        SEL_CTRL: ctrl_d = wr_data;
        SEL_CVEC: cvec_d = wr_data;
        SEL_MVEC: mvec_d = wr_data;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ctrl_q <= '0;
      cvec_q <= '0;
      mvec_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      cvec_q <= cvec_d;
      mvec_q <= mvec_d;
    end
  end

  always_comb begin
    unique case (reg_sel_e'(rd_sel))
      SEL_CTRL: rd_data = ctrl_q;
      SEL_CVEC: rd_data = cvec_q;
      SEL_MVEC: rd_data = mvec_q;
      default:  rd_data = '0;
    endcase
  end

  // R2
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en && wr_sel == 2'd1) |=> cvec_q == $past(wr_data));
endmodule

// File: rtl/irq_src_latch.sv
module irq_src_latch (
  input  logic clk,
  input  logic rst_q,
  input  logic en,
  input  logic event_in,
  input  logic served,
  input  logic hold_mode,
  input  logic fifo_empty,
  output logic pending_q
);
  logic evt_q;
  logic rise;
  logic pending_d;

  assign rise = event_in & ~evt_q;

  always_comb begin
    pending_d = pending_q;
    if (!en)
      pending_d = 1'b0;
    else if (rise)
      pending_d = 1'b1;
    else if (hold_mode ? fifo_empty : served)
      pending_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      evt_q     <= 1'b0;
      pending_q <= 1'b0;
    end else begin
      evt_q     <= event_in;
      pending_q <= pending_d;
    end
  end

  // R4
  latch_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (en && event_in && !evt_q) |=> pending_q);
  // R6
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (en && served && !hold_mode && !rise) |=> !pending_q);
  // R7
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (en && hold_mode && pending_q && !fifo_empty) |=> pending_q);
  // R8
  no_pend_when_off_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !en |=> !pending_q);
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
  import irq_req_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_q,
  input  src_cfg_t [NUM_SRC-1:0]         cfg,
  input  logic     [NUM_SRC-1:0]         pending,
  input  logic     [NUM_SRC-1:0][VEC_W-1:0] vec,
  input  logic                           iack_valid,
  input  logic     [LVL_W-1:0]           iack_level,
  output logic     [NUM_SRC-1:0]         served,
  output logic                           iack_done_q,
  output logic     [VEC_W-1:0]           iack_vector_q,
  output logic     [NUM_LVL:1]           irq_n
);
  logic [NUM_SRC-1:0] active, match;
  logic [NUM_LVL:0]   line_d;
  logic               done_d;
  logic [VEC_W-1:0]   vector_d;

  always_comb begin
    line_d   = '1;
    served   = '0;
    vector_d = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      active[s] = pending[s] & cfg[s].en & (cfg[s].lvl != '0);
      match[s]  = iack_valid & active[s] & (cfg[s].lvl == iack_level);
      if (active[s]) line_d[cfg[s].lvl] = 1'b0;
      // a higher source index outranks a lower one at the same level
      if (match[s]) begin
        served   = '0;
        served[s] = 1'b1;
        vector_d = vec[s];
      end
    end
    done_d = |served;
  end

  assign irq_n = line_d[NUM_LVL:1];

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      iack_done_q   <= 1'b0;
      iack_vector_q <= '0;
    end else begin
      iack_done_q   <= done_d;
      iack_vector_q <= vector_d;
    end
  end

  // R5
  done_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_q)
    iack_done_q |-> $past(iack_valid));
  // R5
  idle_vector_zero_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !iack_done_q |-> iack_vector_q == '0);
  // R3
  line_count_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $countones(~irq_n) <= NUM_SRC);
  // R10
  marker_first_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (match[SRC_MKR] && match[SRC_CAP]) |=> iack_vector_q == $past(vec[SRC_MKR]));
endmodule

// File: rtl/dual_irq_requester.sv
module dual_irq_requester
  import irq_req_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [7:0]       wr_data,
  input  logic [1:0]       rd_sel,
  output logic [7:0]       rd_data,
  input  logic             release_on_empty,
  input  logic             fifo_empty,
  input  logic             cap_event,
  input  logic             mkr_event,
  input  logic             iack_valid,
  input  logic [2:0]       iack_level,
  output logic             iack_done,
  output logic [7:0]       iack_vector,
  output logic [7:1]       irq_n
);
  logic [1:0]                     rst_sync_q;
  logic                           rst_q;
  logic [VEC_W-1:0]               ctrl_q, cvec_q, mvec_q;
  src_cfg_t [NUM_SRC-1:0]         cfg;
  logic [NUM_SRC-1:0]             pending, served, evt, hold;
  logic [NUM_SRC-1:0][VEC_W-1:0]  vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  irq_reg_file u_regs (
    .clk(clk), .rst_q(rst_q), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .ctrl_q(ctrl_q), .cvec_q(cvec_q), .mvec_q(mvec_q)
  );

  assign cfg[SRC_CAP] = src_cfg_t'(ctrl_q[NIB_W-1:0]);
  assign cfg[SRC_MKR] = src_cfg_t'(ctrl_q[2*NIB_W-1:NIB_W]);
  assign vec[SRC_CAP] = cvec_q;
  assign vec[SRC_MKR] = mvec_q;
  assign evt[SRC_CAP] = cap_event;
  assign evt[SRC_MKR] = mkr_event;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    if (s == SRC_CAP) begin : g_mode
      assign hold[s] = release_on_empty;
    end else begin : g_ack_only
      assign hold[s] = 1'b0;
    end
    irq_src_latch u_latch (
      .clk(clk), .rst_q(rst_q), .en(cfg[s].en), .event_in(evt[s]),
      .served(served[s]), .hold_mode(hold[s]), .fifo_empty(fifo_empty),
      .pending_q(pending[s])
    );
  end

  irq_ack_unit u_ack (
    .clk(clk), .rst_q(rst_q), .cfg(cfg), .pending(pending), .vec(vec),
    .iack_valid(iack_valid), .iack_level(iack_level), .served(served),
    .iack_done_q(iack_done), .iack_vector_q(iack_vector), .irq_n(irq_n)
  );

  // R9
  marker_release_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (served[SRC_MKR] && !(mkr_event && !$past(mkr_event))) |=> !pending[SRC_MKR]);
endmodule

// File: tb/sim_dual_irq_requester.sv
module sim_dual_irq_requester;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, wr_en, release_on_empty, fifo_empty, cap_event, mkr_event, iack_valid;
  logic [1:0] wr_sel, rd_sel;
  logic [7:0] wr_data, rd_data, iack_vector;
  logic [2:0] iack_level;
  logic       iack_done;
  logic [7:1] irq_n;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_irq_requester u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .release_on_empty(release_on_empty),
    .fifo_empty(fifo_empty), .cap_event(cap_event), .mkr_event(mkr_event),
    .iack_valid(iack_valid), .iack_level(iack_level), .iack_done(iack_done),
    .iack_vector(iack_vector), .irq_n(irq_n)
  );

  task automatic check(string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  function automatic int line_mask(int lvl);
    return (lvl == 0) ? 7'h7F : (7'h7F & ~(7'h1 << (lvl - 1)));
  endfunction

  task automatic step(); @(negedge clk); endtask

  task automatic wreg(int sel, int data);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 8'(data);
    step();
    wr_en = 1'b0;
  endtask

  task automatic rreg(int sel, output int val);
    rd_sel = 2'(sel); #1; val = rd_data;
  endtask

  task automatic pulse(bit mkr);
    if (mkr) mkr_event = 1'b1; else cap_event = 1'b1;
    step();
    mkr_event = 1'b0; cap_event = 1'b0;
  endtask

  task automatic ack(int lvl, output int done, output int vec);
    iack_valid = 1'b1; iack_level = 3'(lvl);
    step();
    done = iack_done; vec = iack_vector;
    iack_valid = 1'b0;
  endtask

  task automatic t_reset();
    int v;
    check("R1 irq_n", irq_n, 7'h7F);
    check("R1 done", iack_done, 0);
    check("R1 vector", iack_vector, 0);
    for (int s = 0; s < 3; s++) begin rreg(s, v); check("R1 reg", v, 0); end
  endtask

  task automatic t_regs();
    int v;
    wreg(1, 8'h3C); wreg(2, 8'hA5); wreg(0, 8'h00); wreg(3, 8'hFF);
    rreg(1, v); check("R2 cap vec", v, 8'h3C);
    rreg(2, v); check("R2 mkr vec", v, 8'hA5);
    rreg(0, v); check("R2 ctrl", v, 8'h00);
    rreg(3, v); check("R2 code3", v, 0);
  endtask

  task automatic t_decode();
    release_on_empty = 1'b0;
    for (int l = 1; l < 8; l++) begin
      wreg(0, 8'h08 | l);
      pulse(0);
      check($sformatf("R3 cap level %0d", l), irq_n, line_mask(l));
      wreg(0, 8'h00);
      check("R8 enable clear withdraws", irq_n, 7'h7F);
    end
    wreg(0, 8'h08); pulse(0);
    check("R3 level 0 silent", irq_n, 7'h7F);
    wreg(0, 8'hD0); pulse(1);
    check("R3 marker level 5", irq_n, line_mask(5));
    wreg(0, 8'h00);
  endtask

  task automatic t_ack_mode();
    int d, v;
    wreg(1, 8'h5A); wreg(0, 8'h0A); release_on_empty = 1'b0;
    cap_event = 1'b1; step();
    check("R4 latched", irq_n, line_mask(2));
    ack(5, d, v);
    check("R5 miss done", d, 0); check("R5 miss vec", v, 0);
    check("R5 miss keeps", irq_n, line_mask(2));
    ack(2, d, v);
    check("R5 done", d, 1); check("R5 vector", v, 8'h5A);
    check("R6 released", irq_n, 7'h7F);
    step();
    check("R5 one-cycle done", iack_done, 0);
    step();
    check("R4 held event no relatch", irq_n, 7'h7F);
    cap_event = 1'b0; step();
    pulse(0);
    check("R4 new rise relatches", irq_n, line_mask(2));
    wreg(0, 8'h02); wreg(0, 8'h0A);
    check("R8 stays withdrawn", irq_n, 7'h7F);
  endtask

  task automatic t_hold_mode();
    int d, v;
    release_on_empty = 1'b1; fifo_empty = 1'b0;
    wreg(0, 8'h0B); pulse(0);
    ack(3, d, v);
    check("R7 done", d, 1); check("R7 vector", v, 8'h5A);
    check("R7 survives ack", irq_n, line_mask(3));
    step();
    check("R7 still asserted", irq_n, line_mask(3));
    fifo_empty = 1'b1; step();
    check("R7 released on empty", irq_n, 7'h7F);
    fifo_empty = 1'b0;
  endtask

  task automatic t_marker();
    int d, v;
    release_on_empty = 1'b1;
    wreg(2, 8'hC3); wreg(0, 8'hE0); pulse(1);
    check("R9 latched", irq_n, line_mask(6));
    ack(6, d, v);
    check("R9 vector", v, 8'hC3);
    check("R9 released in hold mode", irq_n, 7'h7F);
    pulse(1); wreg(0, 8'h60);
    check("R8 marker withdrawn", irq_n, 7'h7F);
    release_on_empty = 1'b0;
  endtask

  task automatic t_prio();
    int d, v;
    wreg(0, 8'hCC);
    cap_event = 1'b1; mkr_event = 1'b1; step();
    cap_event = 1'b0; mkr_event = 1'b0;
    ack(4, d, v);
    check("R10 marker first", v, 8'hC3);
    check("R10 capture stays", irq_n, line_mask(4));
    ack(4, d, v);
    check("R10 capture second", v, 8'h5A);
    check("R10 both released", irq_n, 7'h7F);
    wreg(0, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_sel = 0; wr_data = 0; rd_sel = 0;
    release_on_empty = 0; fifo_empty = 0; cap_event = 0; mkr_event = 0;
    iack_valid = 0; iack_level = 0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    t_reset();
    t_regs();
    t_decode();
    t_ack_mode();
    t_hold_mode();
    t_marker();
    t_prio();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule